// File: doc/BRIEF.md
# Smart Card Character Waiting Timer

This block measures the gap between characters on a smart card line and raises a flag when that gap grows too long. Software loads a 32-bit reload value as four bytes through a simple write port. The counter counts down once per elementary time unit (etu) tick. When it runs out, a sticky timeout flag goes high.

Software sets the reload value while counting is switched off. It then turns counting on, and the count starts from the captured value. When the serial engine beside this block is in charge of the line (UART mode), every start bit re-arms the count from the captured value. The start bit can be one the engine sends or one it receives, so the timeout only fires if the line stays quiet for the whole programmed number of etus. The serial engine itself lies outside this block.

Top module: `wait_time_counter`

## Requirements
- R1: During and straight after a synchronous active-high reset, `timeout` is 0. The byte registers, the captured reload value and the count are all zero.
- R2: Write address 0 holds bits 7:0 of the 32-bit reload value, address 1 holds bits 15:8, address 2 holds bits 23:16 and address 3 holds bits 31:24.
- R3: A write to address 2 while `count_en` is 0 captures the reload value into the hold register at that clock edge. The captured value combines the new byte 2 with the current bytes 0, 1 and 3.
- R4: A write to address 0, 1 or 3 leaves the hold register unchanged. A write to address 2 while `count_en` is 1 also leaves it unchanged.
- R5: While `count_en` is 0, the count follows the hold register and etu ticks have no effect. Setting `count_en` at least one cycle after the capturing write starts the count from the captured value.
- R6: While `count_en` is 1, each `etu_tick` lowers the count by one. For a reload value N ≥ 1, `timeout` rises at the edge of the N-th tick and not before. For N = 0, it rises at the first tick.
- R7: Once the count reaches zero it stays at zero and does not wrap. A later tick therefore sets the flag again after it has been cleared.
- R8: `timeout` stays at 1 until a `flag_clr` pulse clears it. If an expiry and `flag_clr` occur in the same cycle, the flag ends up at 1.
- R9: With `count_en` and `uart_mode` both at 1, a pulse on `tx_start` or `rx_start` reloads the count from the hold register.
- R10: With `uart_mode` at 0, `tx_start` and `rx_start` have no effect on the count.
- R11: If a reload by start bit and an etu tick fall in the same cycle, the reload wins and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte register index, 0 least significant |
| wr_data | input | 8 | Byte write data |
| count_en | input | 1 | 1 runs the counter; 0 stops it and allows capture |
| uart_mode | input | 1 | 1 lets start-bit events re-arm the count |
| tx_start | input | 1 | One-cycle pulse: start bit sent |
| rx_start | input | 1 | One-cycle pulse: start bit received |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| flag_clr | input | 1 | One-cycle pulse clearing the timeout flag |
| timeout | output | 1 | Sticky timeout flag |

## Verification
The bench measures the exact tick on which the flag rises for small, multi-byte and zero reload values. A design off by one would flag a tick early or late, and a design that dropped a byte would flag far too soon. It writes byte 2 while the counter is enabled, and writes other bytes alone, to catch a hold register that captures too freely. It fires start bits with and without UART mode, and together with a tick in the same cycle: a design with the wrong priority would flag one tick early, and one that ignored the mode select would never expire. It also clears the flag once the count has run out to expose a counter that wraps, and it pulses clear on an expiry cycle to expose a clear that wins over the set.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        CNT_STAY = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_STEP = 2'd2
    } cnt_op_e;

    typedef struct packed {
        logic enable;
        logic uart_mode;
        logic start_evt;
        logic tick;
    } cnt_ctl_t;

    // Re-arm request: start bit seen while the serial engine owns the line.
    function automatic logic rearm(cnt_ctl_t c);
        return c.enable && c.uart_mode && c.start_evt;
    endfunction

    // Next counter operation; a reload outranks a tick.
    function automatic cnt_op_e pick_op(cnt_ctl_t c, logic at_zero);
        if (!c.enable)
            return CNT_LOAD;
        if (rearm(c))
            return CNT_LOAD;
        if (c.tick && !at_zero)
            return CNT_STEP;
        return CNT_STAY;
    endfunction

endpackage

// File: rtl/wtc_byte_bank.sv
module wtc_byte_bank #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4,
    parameter int TRIG_IDX  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_BYTES)-1:0]  wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    input  logic                          count_en,
    output logic [BYTE_W*NUM_BYTES-1:0]   hold_val
);
    localparam int AW    = $clog2(NUM_BYTES);
    localparam int VAL_W = BYTE_W * NUM_BYTES;

    logic [BYTE_W-1:0] byte_q   [NUM_BYTES];
    logic [BYTE_W-1:0] byte_nxt [NUM_BYTES];
    logic [VAL_W-1:0]  next_val;
    logic [VAL_W-1:0]  hold_q;
    logic              capture;

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        always_comb begin
            byte_nxt[i] = byte_q[i];
            if (wr_en && (wr_addr == AW'(i)))
                byte_nxt[i] = wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst)
                byte_q[i] <= '0;
            else
                byte_q[i] <= byte_nxt[i];
        end

        assign next_val[i*BYTE_W +: BYTE_W] = byte_nxt[i];
    end

    assign capture = wr_en && (wr_addr == AW'(TRIG_IDX)) && !count_en;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (capture)
            hold_q <= next_val;
    end

    assign hold_val = hold_q;

    // R4: no capture request, no change of the hold register
    a_r4_hold_steady: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_addr == AW'(TRIG_IDX)) && !count_en) |=> $stable(hold_q));

    // R3: a capturing write stores the written byte in its lane
    a_r3_capture_lane: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == AW'(TRIG_IDX)) && !count_en)
        |=> hold_q[TRIG_IDX*BYTE_W +: BYTE_W] == $past(wr_data));

endmodule

// File: rtl/wtc_down_counter.sv
module wtc_down_counter
    import wtc_pkg::*;
#(
    parameter int VAL_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    input  logic [VAL_W-1:0] hold_val,
    output logic             expire
);
    logic [VAL_W-1:0] cnt_q;
    logic             at_zero;
    logic             near_end;
    cnt_op_e          op;

    assign at_zero  = (cnt_q == '0);
    assign near_end = (cnt_q <= VAL_W'(1));

    always_comb op = pick_op(ctl, at_zero);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else begin
            unique case (op)
                CNT_LOAD: cnt_q <= hold_val;
                CNT_STEP: cnt_q <= cnt_q - VAL_W'(1);
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign expire = ctl.enable && !rearm(ctl) && ctl.tick && near_end;

    // R5: disabled counter follows the hold register
    a_r5_tracks_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl.enable |=> cnt_q == $past(hold_val));

    // R9 / R11: start bit in UART mode reloads, tick or not
    a_r9_rearm_loads: assert property (@(posedge clk) disable iff (rst)
        (ctl.enable && ctl.uart_mode && ctl.start_evt) |=> cnt_q == $past(hold_val));

    // R6: without a reload the count never rises
    a_r6_no_rise: assert property (@(posedge clk) disable iff (rst)
        (ctl.enable && !(ctl.uart_mode && ctl.start_evt)) |=> cnt_q <= $past(cnt_q));

    // R7: zero is terminal until a reload
    a_r7_zero_holds: assert property (@(posedge clk) disable iff (rst)
        (ctl.enable && at_zero && !(ctl.uart_mode && ctl.start_evt)) |=> cnt_q == '0);

endmodule

// File: rtl/wtc_sticky_flag.sv
module wtc_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R8: only a clear pulse lowers the flag
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q);

    // R8: set beats clear in the same cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q);

    // R6: the flag rises only on an expiry
    a_r6_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(set_i));

endmodule

// File: rtl/wait_time_counter.sv
module wait_time_counter
    import wtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       count_en,
    input  logic       uart_mode,
    input  logic       tx_start,
    input  logic       rx_start,
    input  logic       etu_tick,
    input  logic       flag_clr,
    output logic       timeout
);
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 4;
    localparam int TRIG_IDX  = 2;
    localparam int VAL_W     = BYTE_W * NUM_BYTES;

    logic [VAL_W-1:0] hold_val;
    logic             expire;
    cnt_ctl_t         ctl;

    assign ctl.enable    = count_en;
    assign ctl.uart_mode = uart_mode;
    assign ctl.start_evt = tx_start | rx_start;
    assign ctl.tick      = etu_tick;

    wtc_byte_bank #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES),
        .TRIG_IDX  (TRIG_IDX)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .count_en (count_en),
        .hold_val (hold_val)
    );

    wtc_down_counter #(
        .VAL_W (VAL_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .hold_val (hold_val),
        .expire   (expire)
    );

    wtc_sticky_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (expire),
        .clr_i (flag_clr),
        .flag  (timeout)
    );

    // R10: outside UART mode a start bit cannot cause an expiry by itself
    a_r10_no_start_expiry: assert property (@(posedge clk) disable iff (rst)
        (!uart_mode && !etu_tick) |-> !expire);

    // R1 / R5: nothing expires while stopped
    a_r5_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
        !count_en |-> !expire);

endmodule

// File: tb/tb_wait_time_counter.sv
module tb_wait_time_counter;

    typedef struct packed {
        logic [31:0] reload;
        logic [31:0] ticks;
        logic        exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'd3,          32'd2,     1'b0},
        '{32'd3,          32'd3,     1'b1},
        '{32'd1,          32'd1,     1'b1},
        '{32'd0,          32'd1,     1'b1},
        '{32'h0000_0102,  32'd257,   1'b0},
        '{32'h0000_0102,  32'd258,   1'b1},
        '{32'h0100_0000,  32'd1,     1'b0},
        '{32'h0001_0001,  32'd65537, 1'b1},
        '{32'd5,          32'd0,     1'b0}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, count_en, uart_mode, tx_start, rx_start, etu_tick, flag_clr;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       timeout;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    wait_time_counter dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count_en(count_en), .uart_mode(uart_mode), .tx_start(tx_start),
        .rx_start(rx_start), .etu_tick(etu_tick), .flag_clr(flag_clr),
        .timeout(timeout)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: timeout=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic t, input logic tx, input logic rx, input logic c);
        @(negedge clk);
        etu_tick = t; tx_start = tx; rx_start = rx; flag_clr = c;
        @(negedge clk);
        etu_tick = 1'b0; tx_start = 1'b0; rx_start = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            etu_tick = 1'b1;
            repeat (n - 1) @(negedge clk);
            @(negedge clk);
            etu_tick = 1'b0;
        end
    endtask

    // Stop, write all bytes (byte 2 last), clear the flag, then start.
    task automatic load_and_start(input logic [31:0] v);
        @(negedge clk);
        count_en = 1'b0;
        wr_byte(2'd3, v[31:24]);
        wr_byte(2'd1, v[15:8]);
        wr_byte(2'd0, v[7:0]);
        wr_byte(2'd2, v[23:16]);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        count_en = 1'b1;
    endtask

    initial begin
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: timeout=%0b expected run to end", timeout);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; count_en = 1'b0;
        uart_mode = 1'b0; tx_start = 1'b0; rx_start = 1'b0; etu_tick = 1'b0; flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", timeout, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", timeout, 1'b0);

        // R2 R3 R6: vector table of reload values and tick counts
        for (int i = 0; i < NV; i++) begin
            load_and_start(VECS[i].reload);
            ticks(int'(VECS[i].ticks));
            check($sformatf("R6 R2 vec%0d", i), timeout, VECS[i].exp);
        end

        // R5: disabled counter ignores ticks
        load_and_start(32'd1);
        count_en = 1'b0;
        ticks(5);
        check("R5 disabled ignores ticks", timeout, 1'b0);

        // R4: writing byte 2 while enabled leaves hold at 3
        load_and_start(32'd3);
        wr_byte(2'd2, 8'h55);
        count_en = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0);
        count_en = 1'b1;
        ticks(2);
        check("R4 enabled byte2 write early", timeout, 1'b0);
        ticks(1);
        check("R4 enabled byte2 write ignored", timeout, 1'b1);

        // R4: byte 0 write alone does not recapture
        load_and_start(32'd3);
        count_en = 1'b0;
        wr_byte(2'd0, 8'd9);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        count_en = 1'b1;
        ticks(2);
        check("R4 byte0 write early", timeout, 1'b0);
        ticks(1);
        check("R4 byte0 write no capture", timeout, 1'b1);

        // R7: count stays at zero, next tick expires again
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 clear", timeout, 1'b0);
        ticks(1);
        check("R7 no wrap", timeout, 1'b1);

        // R8: sticky with idle cycles
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 sticky", timeout, 1'b1);

        // R8: set wins over clear
        load_and_start(32'd1);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        check("R8 set beats clear", timeout, 1'b1);

        // R9: rx start re-arms in UART mode
        uart_mode = 1'b1;
        load_and_start(32'd4);
        ticks(3);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        ticks(3);
        check("R9 rx rearm", timeout, 1'b0);
        ticks(1);
        check("R9 rx rearm expiry", timeout, 1'b1);

        // R8: flag survives a reload, then clears
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R8 sticky over reload", timeout, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 clear after reload", timeout, 1'b0);

        // R11: tx reload and tick together, reload wins
        load_and_start(32'd2);
        ticks(1);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        ticks(1);
        check("R11 reload beats tick", timeout, 1'b0);
        ticks(1);
        check("R11 reload beats tick expiry", timeout, 1'b1);

        // R10: start bits ignored outside UART mode
        uart_mode = 1'b0;
        load_and_start(32'd3);
        ticks(2);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        ticks(1);
        check("R10 start ignored", timeout, 1'b1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule